// File: doc/BRIEF.md
# Four-Variable Multiplexer Function Generator

This block is a configurable logic cell that evaluates any Boolean function of four variables through a single 8-to-1 multiplexer. Three of the four variables act as the multiplexer's select lines. The fourth variable is called the residue. Each of the eight data inputs is fed by a small four-way selector. A 2-bit code picks the selector's value: constant 0, constant 1, the residue, or the inverted residue. A function of N+1 variables therefore needs only N select lines.

The sixteen code bits sit in a configuration register. The register loads from a word port on a rising clock edge while a load strobe is high. The function output is combinational from the stored codes and the live variable inputs. A parameter picks which variable is the residue. The other variables drive the select lines in ascending index order, so the lowest-numbered one goes to the least significant select line. Software or a test model converts a truth table into codes. For data input i, look at the two minterms it covers, one with the residue at 0 and one with the residue at 1. If both are true, the code is constant 1. If neither is true, the code is constant 0. If only the residue-1 minterm is true, the code is the residue. If only the residue-0 minterm is true, the code is the inverted residue.

Top module: `fn_mux_gen`

## Requirements
- R1: While rst_ni is low and after its release with no load, the stored codes are all zero and func_o is 0 for every variable pattern.
- R2: When cfg_load_i is high at a rising clk_i edge, cfg_word_i is stored, and from that edge on func_o follows the new codes.
- R3: When cfg_load_i is low at a rising edge, the stored codes keep their value, and changes on cfg_word_i have no effect on func_o.
- R4: Code 2'b00 on the selected data input makes func_o equal 0.
- R5: Code 2'b01 on the selected data input makes func_o equal 1.
- R6: Code 2'b10 on the selected data input makes func_o equal the residue variable.
- R7: Code 2'b11 on the selected data input makes func_o equal the inverse of the residue variable.
- R8: Data input i takes its code from cfg_word bits [2i+1:2i]. The select value is formed from the non-residue variables in ascending index order, with the lowest-indexed one as its LSB.
- R9: Codes derived from any 16-entry truth table by the minterm-pair rule make func_o equal the table entry at index var_i, for all 16 patterns.
- R10: Parameter RES_POS selects which bit of var_i is the residue. With RES_POS=0, bits 3:1 form the select value and R9 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Load strobe for the configuration word |
| cfg_word_i | input | 16 | Eight 2-bit residue codes |
| var_i | input | 4 | The four function variables |
| func_o | output | 1 | Function value |

## Verification
A configuration load and a function evaluation can fall in the same cycle. The bench provokes this by changing var_i and presenting a new word with the strobe high in the same half-cycle. Before the edge, func_o must still follow the old truth table for the new variable pattern. After the edge, it must follow the new table for that same pattern. Both expected values are taken from the bench's own truth tables, not from the design.

// File: rtl/fmg_pkg.sv
package fmg_pkg;
  typedef enum logic [1:0] {
    CODE_ZERO = 2'b00,
    CODE_ONE  = 2'b01,
    CODE_VAR  = 2'b10,
    CODE_NVAR = 2'b11
  } res_code_e;
  localparam int unsigned CODE_W = 2;
endpackage

// File: rtl/fmg_cfg_reg.sv
module fmg_cfg_reg #(
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] word_i,
  output logic [CFG_W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= '0;
    else if (load_i) cfg_o <= word_i;
  end

  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cfg_o == $past(word_i)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_o)); // R3
endmodule

// File: rtl/fmg_var_split.sv
module fmg_var_split #(
  parameter int unsigned NVAR    = 4,
  parameter int unsigned RES_POS = NVAR - 1
) (
  input  logic [NVAR-1:0] var_i,
  output logic [NVAR-2:0] sel_o,
  output logic            res_o
);
  assign res_o = var_i[RES_POS];
  for (genvar j = 0; j < NVAR - 1; j++) begin : g_sel
    localparam int unsigned SRC = (j < RES_POS) ? j : j + 1;
    assign sel_o[j] = var_i[SRC];
  end
endmodule

// File: rtl/fmg_residue_sel.sv
module fmg_residue_sel
  import fmg_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              res_i,
  output logic              d_o
);
  always_comb begin
    unique case (res_code_e'(code_i))
      CODE_ZERO: d_o = 1'b0;
      CODE_ONE:  d_o = 1'b1;
      CODE_VAR:  d_o = res_i;
      CODE_NVAR: d_o = ~res_i;
      default:   d_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fmg_mux_tree.sv
module fmg_mux_tree #(
  parameter int unsigned NSEL = 3
) (
  input  logic [(1<<NSEL)-1:0] data_i,
  input  logic [NSEL-1:0]      sel_i,
  output logic                 y_o
);
  localparam int unsigned NIN = 1 << NSEL;
  localparam int unsigned NNODE = 2 * NIN - 1;

  logic [NNODE-1:0] stg;
  assign stg[NIN-1:0] = data_i;

  // level l starts at offset 2*NIN - 2*(NIN>>l); select bit l resolves index bit l
  for (genvar l = 0; l < NSEL; l++) begin : g_lvl
    localparam int unsigned OFF_IN  = 2 * NIN - 2 * (NIN >> l);
    localparam int unsigned OFF_OUT = 2 * NIN - 2 * (NIN >> (l + 1));
    for (genvar m = 0; m < (NIN >> (l + 1)); m++) begin : g_node
      assign stg[OFF_OUT+m] = sel_i[l] ? stg[OFF_IN+2*m+1] : stg[OFF_IN+2*m];
    end
  end

  assign y_o = stg[NNODE-1];
endmodule

// File: rtl/fn_mux_gen.sv
module fn_mux_gen
  import fmg_pkg::*;
#(
  parameter int unsigned NVAR    = 4,
  parameter int unsigned RES_POS = NVAR - 1
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   cfg_load_i,
  input  logic [(1<<(NVAR-1))*fmg_pkg::CODE_W-1:0] cfg_word_i,
  input  logic [NVAR-1:0]                        var_i,
  output logic                                   func_o
);
  localparam int unsigned NSEL  = NVAR - 1;
  localparam int unsigned NIN   = 1 << NSEL;
  localparam int unsigned CFG_W = NIN * CODE_W;

  logic [CFG_W-1:0] cfg_q;
  logic [NSEL-1:0]  sel_w;
  logic             res_w;
  logic [NIN-1:0]   data_w;

  fmg_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .word_i (cfg_word_i),
    .cfg_o  (cfg_q)
  );

  fmg_var_split #(.NVAR(NVAR), .RES_POS(RES_POS)) u_split (
    .var_i (var_i),
    .sel_o (sel_w),
    .res_o (res_w)
  );

  for (genvar i = 0; i < NIN; i++) begin : g_res
    fmg_residue_sel u_rsel (
      .code_i (cfg_q[CODE_W*i +: CODE_W]),
      .res_i  (res_w),
      .d_o    (data_w[i])
    );
  end

  fmg_mux_tree #(.NSEL(NSEL)) u_tree (
    .data_i (data_w),
    .sel_i  (sel_w),
    .y_o    (y_w)
  );

  logic y_w;
  assign func_o = y_w;

  logic [CODE_W-1:0] cur_code;
  assign cur_code = cfg_q[CODE_W*sel_w +: CODE_W];

  AST_CODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_code == CODE_ZERO |-> !func_o); // R4
  AST_CODE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_code == CODE_ONE |-> func_o); // R5
  AST_CODE_VAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_code == CODE_VAR |-> func_o == var_i[RES_POS]); // R6
  AST_CODE_NVAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_code == CODE_NVAR |-> func_o != var_i[RES_POS]); // R7
endmodule

// File: tb/sim_fn_mux_gen.sv
module sim_fn_mux_gen;
  localparam int CLK_PER = 10;
  localparam int WD_MAX  = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld0 = 1'b0, ld1 = 1'b0;
  logic [15:0] w0 = '0, w1 = '0;
  logic [3:0] v0 = '0, v1 = '0;
  logic f0, f1;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  fn_mux_gen u0 (.clk_i(clk), .rst_ni(rst_n), .cfg_load_i(ld0), .cfg_word_i(w0),
                 .var_i(v0), .func_o(f0));
  fn_mux_gen #(.RES_POS(0)) u1 (.clk_i(clk), .rst_ni(rst_n), .cfg_load_i(ld1),
                 .cfg_word_i(w1), .var_i(v1), .func_o(f1));

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ins(input logic [2:0] s, input logic x, input int p);
    logic [3:0] r;
    int k = 0;
    for (int b = 0; b < 4; b++) begin
      if (b == p) r[b] = x;
      else begin r[b] = s[k]; k++; end
    end
    return r;
  endfunction

  function automatic logic [15:0] derive(input logic [15:0] tt, input int p);
    logic [15:0] c;
    for (int i = 0; i < 8; i++) begin
      logic m0, m1;
      m0 = tt[ins(3'(i), 1'b0, p)];
      m1 = tt[ins(3'(i), 1'b1, p)];
      if (m0 && m1)        c[2*i +: 2] = 2'b01;
      else if (!m0 && !m1) c[2*i +: 2] = 2'b00;
      else if (m1)         c[2*i +: 2] = 2'b10;
      else                 c[2*i +: 2] = 2'b11;
    end
    return c;
  endfunction

  task automatic load(input int inst, input logic [15:0] w);
    @(negedge clk);
    if (inst == 0) begin ld0 = 1'b1; w0 = w; end
    else           begin ld1 = 1'b1; w1 = w; end
    @(negedge clk);
    ld0 = 1'b0; ld1 = 1'b0;
  endtask

  task automatic sweep(input int inst, input logic [15:0] tt, input string req);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      if (inst == 0) v0 = 4'(v); else v1 = 4'(v);
      #1;
      chk(inst == 0 ? f0 : f1, tt[v], req);
    end
  endtask

  initial begin : wd
    for (int c = 0; c < WD_MAX; c++) begin
      @(posedge clk);
      if (done) disable wd;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] tt, tt2;
    repeat (3) @(negedge clk);
    sweep(0, 16'h0000, "R1");
    rst_n = 1'b1;
    sweep(0, 16'h0000, "R1");
    sweep(1, 16'h0000, "R1");

    // R4..R7 uniform codes, residue var_i[3] for u0, var_i[0] for u1
    load(0, 16'h0000); sweep(0, 16'h0000, "R4");
    load(0, 16'h5555); sweep(0, 16'hFFFF, "R5");
    load(0, 16'hAAAA); sweep(0, 16'hFF00, "R6");
    load(0, 16'hFFFF); sweep(0, 16'h00FF, "R7");
    load(1, 16'hAAAA); sweep(1, 16'hAAAA, "R10");

    // R8 one-hot constant-1 code on data input k
    for (int k = 0; k < 8; k++) begin
      load(0, 16'(2'b01) << (2*k));
      tt = '0; tt[k] = 1'b1; tt[k+8] = 1'b1;
      sweep(0, tt, "R8");
      load(1, 16'(2'b01) << (2*k));
      tt = '0; tt[2*k] = 1'b1; tt[2*k+1] = 1'b1;
      sweep(1, tt, "R8");
    end

    // R9/R10 derived from random and patterned tables
    for (int n = 0; n < 24; n++) begin
      tt = (n == 0) ? 16'h6996 : (n == 1) ? 16'h8001 : 16'($urandom);
      load(0, derive(tt, 3)); sweep(0, tt, "R9");
      load(1, derive(tt, 0)); sweep(1, tt, "R10");
    end

    // R3 strobe low: word changes ignored
    tt = 16'h3C5A;
    load(0, derive(tt, 3));
    @(negedge clk); w0 = derive(~tt, 3);
    repeat (2) @(negedge clk);
    sweep(0, tt, "R3");

    // R2 load and evaluation in the same cycle
    for (int v = 0; v < 16; v++) begin
      tt2 = 16'($urandom);
      @(negedge clk);
      v0 = 4'(v); w0 = derive(tt2, 3); ld0 = 1'b1;
      #1 chk(f0, tt[v], "R2 before edge");
      @(posedge clk); #1;
      chk(f0, tt2[v], "R2 after edge");
      @(negedge clk); ld0 = 1'b0;
      tt = tt2;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule